// File: doc/BRIEF.md
# Packet DRAM Power-State Controller

This block tracks the power mode of one packet-protocol DRAM device. Each cycle it may receive one decoded row- or column-packet command, with two flags: whether the packet names this device, and whether it was broadcast to every device. It also receives a request to leave a low-power mode, and a two-step reset handshake made of an arm pulse followed by a release pulse. From these inputs it keeps the device in an idle mode, one of three active modes, or one of four low-power modes. Each low-power mode records whether it was entered from idle or from an active mode, so that leaving it returns the device to that mode.

Two pieces of derived timing ride on the state. A column-packet framing enable rises a programmable number of cycles after the device becomes active. A residence counter watches the nap modes and raises a sticky overrun flag once a programmable cycle limit is reached. A hidden conditional-nap bit lets a controller send one nap command to a group of devices, so that only the members that napped last, and have not been activated since, go back to nap.

Top module: `dram_pwr_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is PDN-S and both `col_frame_en` and `nap_overrun` are 0. State codes on `pwr_state`: STBY=0, ATTN=1, ATTNR=2, ATTNW=3, NAP-A=4, NAP-S=5, PDN-A=6, PDN-S=7.
- R2: A `seq_set` pulse arms the reset handshake. A later `seq_clr` pulse then forces PDN-S, clears `nap_overrun` and clears the conditional-nap bit. A `seq_clr` without a prior arm changes nothing, and commands are ignored while the handshake is armed.
- R3: `cmd_op` codes are 0 none, 1 activate, 2 attention, 3 relax, 4 nap request, 5 powerdown request, 6 conditional nap, 7 read, 8 write, with other values ignored. In STBY, an activate or attention command with `cmd_hit`=1 and `cmd_bcast`=0 moves the device to ATTN. The same command sent as a broadcast, or without a hit, leaves it in STBY.
- R4: In any of ATTN, ATTNR or ATTNW, a read with a hit and without broadcast moves the device to ATTNR, and a write with a hit and without broadcast moves it to ATTNW. A broadcast read or write has no effect.
- R5: A relax command with `cmd_hit` or `cmd_bcast` set, received in ATTN, ATTNR or ATTNW, returns the device to STBY.
- R6: A nap request or powerdown request (hit or broadcast) moves the device from STBY to NAP-S or PDN-S, and from any active mode to NAP-A or PDN-A.
- R7: In a low-power mode, `exit_req` returns the device to STBY from NAP-S or PDN-S, and to ATTN from NAP-A or PDN-A. All commands are ignored in the low-power modes.
- R8: The conditional-nap bit reads as 0 after reset. An applied nap request sets it, and an activate with a hit and without broadcast clears it. A conditional-nap command behaves like a nap request only while the bit is set; otherwise it has no effect.
- R9: When the device enters an active mode from STBY or from a low-power mode on edge k, `col_frame_en` goes high on edge k+max(`frame_dly`,1). It stays high while the device remains active, and it is 0 in every non-active mode.
- R10: `nap_overrun` goes high on the edge that ends the `nap_limit`-th consecutive cycle spent in NAP-A or NAP-S. Leaving nap one cycle earlier keeps it low. A `nap_limit` of 0 disables the check, and once set the flag stays high until R1 or R2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_set | input | 1 | Arms the reset handshake |
| seq_clr | input | 1 | Completes the armed reset handshake |
| cmd_op | input | 4 | Decoded command code (see R3) |
| cmd_hit | input | 1 | Packet addresses this device |
| cmd_bcast | input | 1 | Packet is a broadcast |
| exit_req | input | 1 | Leave the current low-power mode |
| frame_dly | input | FRM_W | Framing delay in cycles |
| nap_limit | input | NAP_W | Maximum nap residence in cycles, 0 = unchecked |
| pwr_state | output | 3 | Current power state code |
| col_frame_en | output | 1 | Column-packet framing enabled |
| nap_overrun | output | 1 | Sticky nap residence overrun |

## Verification
Activation is tried with directed, broadcast and unaddressed packets, so that only a directed packet can move the device out of STBY. Nap and powerdown are entered from both STBY and active modes, then exited, which shows that each substate remembers where it was entered from. The conditional-nap command is sent with the hidden bit never set, set by a nap request, and cleared by a directed activate, which covers all three of its paths. Nap residence is ended one cycle before the limit, held through the limit, and run with the limit at zero. The framing delay is measured both after a fresh activation and after leaving NAP-A, with a delay of three and with a delay of zero.

// File: rtl/dpwr_pkg.sv
package dpwr_pkg;

  typedef enum logic [2:0] {
    PS_STBY  = 3'd0,
    PS_ATTN  = 3'd1,
    PS_ATTNR = 3'd2,
    PS_ATTNW = 3'd3,
    PS_NAP_A = 3'd4,
    PS_NAP_S = 3'd5,
    PS_PDN_A = 3'd6,
    PS_PDN_S = 3'd7
  } pstate_e;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_ACT  = 4'd1,
    OP_ATTN = 4'd2,
    OP_RLX  = 4'd3,
    OP_NAP  = 4'd4,
    OP_PDN  = 4'd5,
    OP_CNAP = 4'd6,
    OP_RD   = 4'd7,
    OP_WR   = 4'd8
  } op_e;

  function automatic logic is_attn(input logic [2:0] s);
    return (s == PS_ATTN) || (s == PS_ATTNR) || (s == PS_ATTNW);
  endfunction

  function automatic logic is_nap(input logic [2:0] s);
    return (s == PS_NAP_A) || (s == PS_NAP_S);
  endfunction

  function automatic logic is_low(input logic [2:0] s);
    return s[2];
  endfunction

endpackage

// File: rtl/dpwr_state_core.sv
module dpwr_state_core
  import dpwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       seq_set,
  input  logic       seq_clr,
  input  logic [3:0] cmd_op,
  input  logic       cmd_hit,
  input  logic       cmd_bcast,
  input  logic       exit_req,
  output logic [2:0] state_q,
  output logic [2:0] state_d,
  output logic       armed_q,
  output logic       seq_done
);

  logic       cnap_q, cnap_d;
  logic       armed_d;
  logic       applies, direct;
  pstate_e    cur;
  pstate_e    nap_dst, pdn_dst;

  assign applies  = cmd_hit | cmd_bcast;
  assign direct   = cmd_hit & ~cmd_bcast;
  assign seq_done = armed_q & seq_clr;
  assign cur      = pstate_e'(state_q);
  assign nap_dst  = is_attn(state_q) ? PS_NAP_A : PS_NAP_S;
  assign pdn_dst  = is_attn(state_q) ? PS_PDN_A : PS_PDN_S;

  always_comb begin
    state_d = state_q;
    cnap_d  = cnap_q;
    armed_d = armed_q;
    if (armed_q) begin
      if (seq_clr) begin
        state_d = PS_PDN_S;
        cnap_d  = 1'b0;
        armed_d = 1'b0;
      end
    end else if (seq_set) begin
      armed_d = 1'b1;
    end else if (is_low(state_q)) begin
      if (exit_req)
        state_d = (cur == PS_NAP_A || cur == PS_PDN_A) ? PS_ATTN : PS_STBY;
    end else begin
      case (op_e'(cmd_op))
        OP_ACT: if (direct) begin
          cnap_d = 1'b0;
          if (cur == PS_STBY) state_d = PS_ATTN;
        end
        OP_ATTN: if (direct && cur == PS_STBY) state_d = PS_ATTN;
        OP_RLX:  if (applies && is_attn(state_q)) state_d = PS_STBY;
        OP_NAP:  if (applies) begin
          cnap_d  = 1'b1;
          state_d = nap_dst;
        end
        OP_PDN:  if (applies) state_d = pdn_dst;
        OP_CNAP: if (applies && cnap_q) state_d = nap_dst;
        OP_RD:   if (direct && is_attn(state_q)) state_d = PS_ATTNR;
        OP_WR:   if (direct && is_attn(state_q)) state_d = PS_ATTNW;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_PDN_S;
      cnap_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnap_q  <= cnap_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/dpwr_frame_gate.sv
module dpwr_frame_gate
  import dpwr_pkg::*;
#(
  parameter int FRM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       state_q,
  input  logic [2:0]       state_d,
  input  logic [FRM_W-1:0] frame_dly,
  output logic             frame_en
);

  logic [FRM_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q   <= '0;
      frame_en <= 1'b0;
    end else if (!is_attn(state_d)) begin
      frame_en <= 1'b0;
    end else if (!is_attn(state_q)) begin
      wait_q   <= frame_dly;
      frame_en <= 1'b0;
    end else if (wait_q > FRM_W'(1)) begin
      wait_q <= wait_q - FRM_W'(1);
    end else begin
      frame_en <= 1'b1;
    end
  end

endmodule

// File: rtl/dpwr_nap_watch.sv
module dpwr_nap_watch
  import dpwr_pkg::*;
#(
  parameter int NAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seq_done,
  input  logic [2:0]       state_q,
  input  logic [NAP_W-1:0] nap_limit,
  output logic             overrun
);

  localparam logic [NAP_W-1:0] CNT_MAX = '1;

  logic [NAP_W-1:0] stay_q;
  logic [NAP_W:0]   stay_inc;

  assign stay_inc = {1'b0, stay_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || seq_done) begin
      stay_q  <= '0;
      overrun <= 1'b0;
    end else if (is_nap(state_q)) begin
      if (stay_q != CNT_MAX) stay_q <= stay_q + 1'b1;
      if (nap_limit != '0 && stay_inc >= {1'b0, nap_limit}) overrun <= 1'b1;
    end else begin
      stay_q <= '0;
    end
  end

endmodule

// File: rtl/dram_pwr_fsm.sv
module dram_pwr_fsm
  import dpwr_pkg::*;
#(
  parameter int FRM_W = 4,
  parameter int NAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seq_set,
  input  logic             seq_clr,
  input  logic [3:0]       cmd_op,
  input  logic             cmd_hit,
  input  logic             cmd_bcast,
  input  logic             exit_req,
  input  logic [FRM_W-1:0] frame_dly,
  input  logic [NAP_W-1:0] nap_limit,
  output logic [2:0]       pwr_state,
  output logic             col_frame_en,
  output logic             nap_overrun
);

  logic [2:0] st_q, st_d;
  logic       seq_armed, seq_done;

  dpwr_state_core u_core (
    .clk       (clk),
    .rst       (rst),
    .seq_set   (seq_set),
    .seq_clr   (seq_clr),
    .cmd_op    (cmd_op),
    .cmd_hit   (cmd_hit),
    .cmd_bcast (cmd_bcast),
    .exit_req  (exit_req),
    .state_q   (st_q),
    .state_d   (st_d),
    .armed_q   (seq_armed),
    .seq_done  (seq_done)
  );

  dpwr_frame_gate #(.FRM_W(FRM_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .state_q   (st_q),
    .state_d   (st_d),
    .frame_dly (frame_dly),
    .frame_en  (col_frame_en)
  );

  dpwr_nap_watch #(.NAP_W(NAP_W)) u_nap (
    .clk       (clk),
    .rst       (rst),
    .seq_done  (seq_done),
    .state_q   (st_q),
    .nap_limit (nap_limit),
    .overrun   (nap_overrun)
  );

  assign pwr_state = st_q;

endmodule

// File: rtl/dpwr_chk.sv
module dpwr_chk
  import dpwr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       seq_set,
  input logic       seq_clr,
  input logic [3:0] cmd_op,
  input logic       cmd_hit,
  input logic       cmd_bcast,
  input logic       exit_req,
  input logic [2:0] pwr_state,
  input logic       col_frame_en,
  input logic       nap_overrun,
  input logic       armed
);

  logic quiet;
  assign quiet = !armed && !seq_set;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pwr_state == PS_PDN_S && !col_frame_en && !nap_overrun));

  // R5
  relax_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && is_attn(pwr_state) && cmd_op == OP_RLX && (cmd_hit || cmd_bcast))
    |=> pwr_state == PS_STBY);

  // R6
  pdn_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && pwr_state == PS_STBY && cmd_op == OP_PDN && (cmd_hit || cmd_bcast))
    |=> pwr_state == PS_PDN_S);

  // R7
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && is_low(pwr_state) && !exit_req) |=> $stable(pwr_state));

  // R9
  frame_attn_chk: assert property (@(posedge clk) disable iff (rst)
    col_frame_en |-> is_attn(pwr_state));

  // R10
  overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nap_overrun) |-> is_nap($past(pwr_state)));

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (nap_overrun && !(armed && seq_clr)) |=> nap_overrun);

endmodule

bind dram_pwr_fsm dpwr_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .seq_set      (seq_set),
  .seq_clr      (seq_clr),
  .cmd_op       (cmd_op),
  .cmd_hit      (cmd_hit),
  .cmd_bcast    (cmd_bcast),
  .exit_req     (exit_req),
  .pwr_state    (pwr_state),
  .col_frame_en (col_frame_en),
  .nap_overrun  (nap_overrun),
  .armed        (seq_armed)
);

// File: tb/dram_pwr_fsm_test.sv
module dram_pwr_fsm_test;
  import dpwr_pkg::*;

  localparam int FRM_W = 4;
  localparam int NAP_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seq_set = 1'b0, seq_clr = 1'b0;
  logic [3:0] cmd_op = '0;
  logic cmd_hit = 1'b0, cmd_bcast = 1'b0, exit_req = 1'b0;
  logic [FRM_W-1:0] frame_dly = 4'd3;
  logic [NAP_W-1:0] nap_limit = 16'd5;
  logic [2:0] pwr_state;
  logic col_frame_en, nap_overrun;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    st;
    int    frm;
    int    ovr;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  dram_pwr_fsm #(.FRM_W(FRM_W), .NAP_W(NAP_W)) uut (
    .clk(clk), .rst(rst), .seq_set(seq_set), .seq_clr(seq_clr),
    .cmd_op(cmd_op), .cmd_hit(cmd_hit), .cmd_bcast(cmd_bcast),
    .exit_req(exit_req), .frame_dly(frame_dly), .nap_limit(nap_limit),
    .pwr_state(pwr_state), .col_frame_en(col_frame_en),
    .nap_overrun(nap_overrun)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compares results one edge after each driven step
  always @(negedge clk) begin
    item_t it;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      if (it.st  >= 0) cmp(it.tag, "state",   int'(pwr_state),    it.st);
      if (it.frm >= 0) cmp(it.tag, "frame",   int'(col_frame_en), it.frm);
      if (it.ovr >= 0) cmp(it.tag, "overrun", int'(nap_overrun),  it.ovr);
    end
  end

  // Driver: applies one cycle of stimulus and queues the expectation
  task automatic step(input logic [3:0] op, input logic h, input logic b,
                      input logic ex, input logic s, input logic c,
                      input int st, input int frm, input int ovr, input string tag);
    item_t it;
    @(negedge clk);
    cmd_op = op; cmd_hit = h; cmd_bcast = b; exit_req = ex;
    seq_set = s; seq_clr = c;
    @(posedge clk);
    it.st = st; it.frm = frm; it.ovr = ovr; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int st, input int frm, input int ovr, input string tag);
    step(OP_NONE, 0, 0, 0, 0, 0, st, frm, ovr, tag);
  endtask

  task automatic cmd(input logic [3:0] op, input logic h, input logic b,
                     input int st, input int frm, input string tag);
    step(op, h, b, 0, 0, 0, st, frm, -1, tag);
  endtask

  task automatic leave(input int st, input int frm, input int ovr, input string tag);
    step(OP_NONE, 0, 0, 1, 0, 0, st, frm, ovr, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle(7, 0, 0, "R1 reset state");
    leave(0, 0, 0, "R7 exit PDN-S to STBY");
    cmd(OP_ACT, 0, 1, 0, 0, "R3 broadcast activate ignored");
    cmd(OP_ATTN, 0, 0, 0, 0, "R3 unaddressed attention ignored");
    cmd(OP_CNAP, 1, 0, 0, 0, "R8 conditional nap with bit clear");
    cmd(4'd12, 1, 0, 0, 0, "R3 unused code ignored");
    // framing delay 3 after entry
    cmd(OP_ATTN, 1, 0, 1, 0, "R3 directed attention");
    idle(1, 0, -1, "R9 frame k+1");
    idle(1, 0, -1, "R9 frame k+2");
    idle(1, 1, -1, "R9 frame k+3");
    cmd(OP_WR, 1, 0, 3, 1, "R4 write to ATTNW");
    cmd(OP_RD, 1, 0, 2, 1, "R4 read to ATTNR");
    cmd(OP_WR, 1, 1, 2, 1, "R4 broadcast write ignored");
    cmd(OP_NAP, 1, 0, 4, 0, "R6 nap from active to NAP-A");
    idle(4, 0, 0, "R10 nap cycle 1");
    cmd(OP_RLX, 1, 0, 4, 0, "R7 command ignored in nap");
    idle(4, 0, 0, "R10 nap cycle 3");
    leave(1, 0, 0, "R10 exit before limit");
    idle(1, 0, -1, "R9 rearm k+1");
    idle(1, 0, -1, "R9 rearm k+2");
    idle(1, 1, -1, "R9 rearm k+3");
    cmd(OP_RLX, 0, 1, 0, 0, "R5 broadcast relax");
    cmd(OP_CNAP, 1, 0, 5, 0, "R8 conditional nap with bit set");
    leave(0, 0, -1, "R7 exit NAP-S to STBY");
    cmd(OP_ACT, 1, 0, 1, 0, "R8 activate clears bit");
    cmd(OP_RLX, 1, 0, 0, 0, "R5 directed relax");
    cmd(OP_CNAP, 1, 0, 0, 0, "R8 conditional nap after clear");
    cmd(OP_PDN, 1, 0, 7, 0, "R6 powerdown from STBY");
    leave(0, 0, -1, "R7 exit PDN-S");
    cmd(OP_ATTN, 1, 0, 1, 0, "R3 attention again");
    cmd(OP_PDN, 0, 1, 6, 0, "R6 broadcast powerdown to PDN-A");
    leave(1, 0, -1, "R7 exit PDN-A to ATTN");
    cmd(OP_RLX, 1, 0, 0, 0, "R5 relax");
    cmd(OP_NAP, 1, 0, 5, 0, "R6 nap from STBY");
    for (int i = 1; i <= 4; i++) idle(5, 0, 0, "R10 below limit");
    idle(5, 0, 1, "R10 limit reached");
    leave(0, 0, 1, "R10 sticky after exit");
    idle(0, 0, 1, "R10 sticky idle");
    step(OP_NONE, 0, 0, 0, 0, 1, 0, 0, 1, "R2 unarmed release ignored");
    step(OP_NONE, 0, 0, 0, 1, 0, 0, 0, 1, "R2 arm");
    step(OP_ATTN, 1, 0, 0, 0, 0, 0, 0, 1, "R2 command ignored while armed");
    step(OP_NONE, 0, 0, 0, 0, 1, 7, 0, 0, "R2 release to PDN-S");
    @(negedge clk) nap_limit = '0;
    leave(0, 0, 0, "R7 exit");
    cmd(OP_NAP, 1, 0, 5, 0, "R6 nap");
    for (int i = 0; i < 7; i++) idle(5, 0, 0, "R10 limit zero disables");
    leave(0, 0, 0, "R7 exit");
    @(negedge clk) frame_dly = '0;
    cmd(OP_ACT, 1, 0, 1, 0, "R3 activate");
    idle(1, 1, -1, "R9 zero delay acts as one");
    idle(1, 1, -1, "R9 frame held");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule